// File: doc/BRIEF.md
# Delayed-Load Register Commit Stage

This block holds the 32-entry integer register file of an in-order 32-bit core whose loads have a one-instruction delay. Every clock cycle is one instruction slot. The slot can present two results. The first is a load result, given as a destination register and its data. The second is an ALU result, given the same way. The ALU result reaches the register file at the end of its own slot. The load result does not: it first waits in a post-delay holding slot, and it lands at the end of the slot that follows. The instruction right after a load therefore still reads the old register contents.

The holding slot is visible on its own output pair, so that a neighbouring forwarding or merge path can see which register has a load in flight and what data it carries. Two combinational read ports return the architectural register contents. If a newer load targets the register already held in the post-delay slot, the older load is dropped and never lands. While the cache-isolate control is high, loads are discarded. Register 0 always reads as zero.

Top module: `ldwb_commit`

## Requirements
- R1: After reset, every register reads 0 on both read ports, and `pend_dst` and `pend_data` are both 0.
- R2: A load issued in slot k (`ld_dst` nonzero, `cache_iso` low) shows up on `pend_dst`/`pend_data` right after the clock edge ending slot k. During slot k+1 the read ports still return the register's previous value.
- R3: A load held in the post-delay slot is written to its register at the edge that ends the following slot. After that edge the read ports return the loaded data.
- R4: If the load issued in a slot targets the same nonzero register that the post-delay slot holds, the held load is cancelled. Its data never reaches the register file, and the new load takes its place in the post-delay slot.
- R5: An ALU result (`alu_dst` nonzero) is written at the edge ending its own slot. If a held load commits to the same register at that edge, the ALU data wins.
- R6: Register 0 reads as 0 at all times, and any write to it is dropped. `ld_dst` = 0 means that no load is issued. A slot with no load leaves `pend_dst` = 0 and `pend_data` = 0.
- R7: While `cache_iso` is 1, the load issued in that slot is discarded: the post-delay slot becomes 0/0 and the target register never changes. A load already held from an earlier slot still commits, and ALU results are unaffected.
- R8: The two read ports are combinational and independent. Each returns the current content of the register selected by its own index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_dst | input | 5 | Destination of the load issued this slot; 0 = none |
| ld_data | input | 32 | Data of the load issued this slot |
| alu_dst | input | 5 | Destination of the ALU result this slot; 0 = none |
| alu_data | input | 32 | ALU result data |
| cache_iso | input | 1 | Cache-isolate state; 1 discards issued loads |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A register content |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B register content |
| pend_dst | output | 5 | Register held in the post-delay slot |
| pend_data | output | 32 | Data held in the post-delay slot |

## Verification
The hardest case to reach is a three-way collision in a single slot. In it, a held load is due to commit, a newer load targets the same register, and an ALU write may hit that register too. The outcome depends on the cancel rule and on the priority between the write lanes. The bench sets up each case with directed slot pairs: back-to-back loads to one register, and a load followed by an ALU write to the same register. It then runs a long pseudo-random sweep whose destinations are limited to registers 0 to 7, so that such collisions, including ones on register 0, happen often. After every slot it compares all 32 registers and the post-delay slot against a bench model.

// File: rtl/ldwb_pkg.sv
`timescale 1ns/1ps
package ldwb_pkg;
    // Fate of the post-delay load in the current slot
    typedef enum logic [1:0] {
        LDA_IDLE   = 2'd0,
        LDA_COMMIT = 2'd1,
        LDA_CANCEL = 2'd2
    } ld_act_e;
endpackage

// File: rtl/ldwb_pend_slot.sv
`timescale 1ns/1ps
module ldwb_pend_slot #(
    parameter int unsigned AW = 5,
    parameter int unsigned XW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] in_dst,
    input  logic [XW-1:0] in_data,
    output logic [AW-1:0] out_dst,
    output logic [XW-1:0] out_data
);
    typedef struct packed {
        logic [AW-1:0] dst;
        logic [XW-1:0] data;
    } pend_t;

    pend_t slot_d, slot_q;

    always_comb begin
        slot_d.dst  = in_dst;
        slot_d.data = (in_dst != '0) ? in_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_dst  = slot_q.dst;
    assign out_data = slot_q.data;

    AST_PEND_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_dst == '0) |-> (out_data == '0)); // R6
endmodule

// File: rtl/ldwb_commit_arb.sv
`timescale 1ns/1ps
module ldwb_commit_arb
    import ldwb_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned XW = 32
) (
    input  logic [AW-1:0] pend_dst,
    input  logic [XW-1:0] pend_data,
    input  logic [AW-1:0] new_ld_dst,
    input  logic [AW-1:0] alu_dst,
    input  logic [XW-1:0] alu_data,
    output ld_act_e       ld_act,
    output logic          ld_we,
    output logic [AW-1:0] ld_idx,
    output logic [XW-1:0] ld_val,
    output logic          alu_we,
    output logic [AW-1:0] alu_idx,
    output logic [XW-1:0] alu_val
);
    always_comb begin
        if (pend_dst == '0)             ld_act = LDA_IDLE;
        else if (pend_dst == new_ld_dst) ld_act = LDA_CANCEL;
        else                             ld_act = LDA_COMMIT;
        ld_we   = (ld_act == LDA_COMMIT);
        ld_idx  = pend_dst;
        ld_val  = pend_data;
        alu_we  = (alu_dst != '0);
        alu_idx = alu_dst;
        alu_val = alu_data;
    end
endmodule

// File: rtl/ldwb_regfile.sv
`timescale 1ns/1ps
module ldwb_regfile #(
    parameter  int unsigned NREG = 32,
    parameter  int unsigned XW   = 32,
    parameter  int unsigned NRD  = 2,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_we,
    input  logic [AW-1:0]           a_idx,
    input  logic [XW-1:0]           a_val,
    input  logic                    b_we,
    input  logic [AW-1:0]           b_idx,
    input  logic [XW-1:0]           b_val,
    input  logic [NRD-1:0][AW-1:0]  rd_idx,
    output logic [NRD-1:0][XW-1:0]  rd_data
);
    typedef struct packed {
        logic [NREG-1:0][XW-1:0] ent;
    } rf_t;

    rf_t st_d, st_q;

    // Lane a (delayed load) is applied first, lane b (ALU) overrides it.
    always_comb begin
        for (int e = 0; e < NREG; e++) begin
            if (e == 0)
                st_d.ent[e] = '0;
            else if (b_we && (b_idx == AW'(e)))
                st_d.ent[e] = b_val;
            else if (a_we && (a_idx == AW'(e)))
                st_d.ent[e] = a_val;
            else
                st_d.ent[e] = st_q.ent[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = st_q.ent[rd_idx[p]];
    end

    AST_ALU_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && b_idx != '0) |=> (st_q.ent[$past(b_idx)] == $past(b_val))); // R5
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && a_idx != '0 && !(b_we && b_idx == a_idx))
            |=> (st_q.ent[$past(a_idx)] == $past(a_val))); // R3
    AST_ZERO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx[0] == '0) |-> (rd_data[0] == '0)); // R6
endmodule

// File: rtl/ldwb_commit.sv
`timescale 1ns/1ps
module ldwb_commit
    import ldwb_pkg::*;
#(
    parameter  int unsigned NREG = 32,
    parameter  int unsigned XW   = 32,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ld_dst,
    input  logic [XW-1:0] ld_data,
    input  logic [AW-1:0] alu_dst,
    input  logic [XW-1:0] alu_data,
    input  logic          cache_iso,
    input  logic [AW-1:0] rd_a_idx,
    output logic [XW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_idx,
    output logic [XW-1:0] rd_b_data,
    output logic [AW-1:0] pend_dst,
    output logic [XW-1:0] pend_data
);
    localparam int unsigned NRD = 2;

    logic [AW-1:0]          ld_eff_dst;
    ld_act_e                ld_act;
    logic                   ld_we, alu_we;
    logic [AW-1:0]          ld_idx, alu_idx;
    logic [XW-1:0]          ld_val, alu_val;
    logic [NRD-1:0][AW-1:0] rd_idx;
    logic [NRD-1:0][XW-1:0] rd_data;

    // Isolated cache: the issued load goes nowhere
    assign ld_eff_dst = cache_iso ? '0 : ld_dst;

    ldwb_pend_slot #(.AW(AW), .XW(XW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_dst   (ld_eff_dst),
        .in_data  (ld_data),
        .out_dst  (pend_dst),
        .out_data (pend_data)
    );

    ldwb_commit_arb #(.AW(AW), .XW(XW)) u_arb (
        .pend_dst   (pend_dst),
        .pend_data  (pend_data),
        .new_ld_dst (ld_eff_dst),
        .alu_dst    (alu_dst),
        .alu_data   (alu_data),
        .ld_act     (ld_act),
        .ld_we      (ld_we),
        .ld_idx     (ld_idx),
        .ld_val     (ld_val),
        .alu_we     (alu_we),
        .alu_idx    (alu_idx),
        .alu_val    (alu_val)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    ldwb_regfile #(.NREG(NREG), .XW(XW), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (ld_we),
        .a_idx   (ld_idx),
        .a_val   (ld_val),
        .b_we    (alu_we),
        .b_idx   (alu_idx),
        .b_val   (alu_val),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cache_iso && ld_dst != '0)
            |=> (pend_dst == $past(ld_dst) && pend_data == $past(ld_data))); // R2
    AST_ISO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cache_iso |=> (pend_dst == '0 && pend_data == '0)); // R7
    AST_CANCEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_dst != '0 && ld_eff_dst == pend_dst && alu_dst != pend_dst)
            |=> (u_rf.st_q.ent[$past(pend_dst)] == $past(u_rf.st_q.ent[pend_dst]))); // R4
    AST_CANCEL_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_act == LDA_CANCEL) |-> (pend_dst == ld_dst && !cache_iso)); // R4
endmodule

// File: tb/ldwb_commit_tb.sv
`timescale 1ns/1ps
module ldwb_commit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  ld_dst, alu_dst, rd_a_idx, rd_b_idx, pend_dst;
    logic [31:0] ld_data, alu_data, rd_a_data, rd_b_data, pend_data;
    logic        cache_iso;

    always #5 clk = ~clk;

    ldwb_commit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_dst(ld_dst), .ld_data(ld_data),
        .alu_dst(alu_dst), .alu_data(alu_data),
        .cache_iso(cache_iso),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .pend_dst(pend_dst), .pend_data(pend_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_rf [32];
    logic [4:0]  m_pd;
    logic [31:0] m_pv;
    logic [31:0] seed = 32'h1bad_5eed;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] i, output logic [31:0] v);
        rd_a_idx = i;
        #10ps;
        v = rd_a_data;
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            #10ps;
            chk({req, " port A"}, rd_a_data, m_rf[i]);
            chk({req, " port B"}, rd_b_data, m_rf[31 - i]);
        end
        chk({req, " pend_dst"}, {27'd0, pend_dst}, {27'd0, m_pd});
        chk({req, " pend_data"}, pend_data, m_pv);
    endtask

    // One slot: drive at negedge, model updates at posedge, return at negedge
    task automatic slot(input logic [4:0] ld, input logic [31:0] lv,
                        input logic [4:0] ad, input logic [31:0] av, input bit iso);
        logic [4:0] eff;
        ld_dst = ld; ld_data = lv; alu_dst = ad; alu_data = av; cache_iso = iso;
        @(posedge clk);
        eff = iso ? 5'd0 : ld;
        if (m_pd != eff) m_rf[m_pd] = m_pv;
        m_rf[0] = '0;
        if (ad != 5'd0) m_rf[ad] = av;
        m_rf[0] = '0;
        m_pd = eff;
        m_pv = (eff != 5'd0) ? lv : 32'd0;
        @(negedge clk);
        ld_dst = '0; ld_data = '0; alu_dst = '0; alu_data = '0; cache_iso = 1'b0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0;
        ld_dst = '0; ld_data = '0; alu_dst = '0; alu_data = '0; cache_iso = 1'b0;
        rd_a_idx = '0; rd_b_idx = '0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pd = '0; m_pv = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_all("R1 reset");

        // R2: load visible in post-delay slot, register still old
        slot(5'd3, 32'hAAAA_0003, 5'd0, 32'd0, 1'b0);
        chk("R2 pend_dst", {27'd0, pend_dst}, 32'd3);
        chk("R2 pend_data", pend_data, 32'hAAAA_0003);
        rd(5'd3, v); chk("R2 old value in delay slot", v, 32'd0);
        // R3: lands after following slot
        slot(5'd0, 32'd0, 5'd0, 32'd0, 1'b0);
        rd(5'd3, v); chk("R3 committed", v, 32'hAAAA_0003);
        chk("R6 idle pend", {27'd0, pend_dst} | pend_data, 32'd0);

        // R4: newer load to same register cancels older
        slot(5'd5, 32'hBBBB_0005, 5'd0, 32'd0, 1'b0);
        slot(5'd5, 32'hCCCC_0005, 5'd0, 32'd0, 1'b0);
        rd(5'd5, v); chk("R4 older load lost", v, 32'd0);
        chk("R4 newer pending", pend_data, 32'hCCCC_0005);
        slot(5'd0, 32'd0, 5'd0, 32'd0, 1'b0);
        rd(5'd5, v); chk("R4 newer lands", v, 32'hCCCC_0005);

        // R5: ALU beats committing load
        slot(5'd7, 32'hDDDD_0007, 5'd0, 32'd0, 1'b0);
        slot(5'd0, 32'd0, 5'd7, 32'hEEEE_0007, 1'b0);
        rd(5'd7, v); chk("R5 ALU wins", v, 32'hEEEE_0007);
        slot(5'd0, 32'd0, 5'd8, 32'h1234_5678, 1'b0);
        rd(5'd8, v); chk("R5 ALU lands in own slot", v, 32'h1234_5678);

        // R6: register 0 writes dropped
        slot(5'd0, 32'hFFFF_FFFF, 5'd0, 32'hFFFF_FFFF, 1'b0);
        chk("R6 no load pend", {27'd0, pend_dst} | pend_data, 32'd0);
        rd(5'd0, v); chk("R6 zero reg", v, 32'd0);
        chk_all("R6 state");

        // R7: isolate discards issued load, earlier one still commits
        slot(5'd10, 32'h0000_A00A, 5'd0, 32'd0, 1'b0);
        slot(5'd9, 32'h9999_0009, 5'd12, 32'h0000_0C0C, 1'b1);
        chk("R7 pend cleared", {27'd0, pend_dst} | pend_data, 32'd0);
        rd(5'd10, v); chk("R7 earlier load commits", v, 32'h0000_A00A);
        rd(5'd12, v); chk("R7 ALU unaffected", v, 32'h0000_0C0C);
        slot(5'd0, 32'd0, 5'd0, 32'd0, 1'b0);
        rd(5'd9, v); chk("R7 discarded load absent", v, 32'd0);
        // R7: isolate on a load to the pending register does not cancel it
        slot(5'd11, 32'h0000_B00B, 5'd0, 32'd0, 1'b0);
        slot(5'd11, 32'h0000_0BAD, 5'd0, 32'd0, 1'b1);
        rd(5'd11, v); chk("R7 no cancel under isolate", v, 32'h0000_B00B);
        chk_all("R8 directed");

        // Sweep over registers 0..7 to force collisions (R3 R4 R5 R6 R7 R8)
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]  l, a;
            logic [31:0] lv, av;
            bit iso;
            seed = nxt(seed); l  = {2'b00, seed[2:0]}; a = {2'b00, seed[6:4]};
            iso = (seed[11:8] == 4'h0);
            if (seed[12]) a = 5'd0;
            seed = nxt(seed); lv = seed;
            seed = nxt(seed); av = seed;
            slot(l, lv, a, av, iso);
            chk_all("R3/R4/R5 sweep");
        end

        finish_run();
    end
endmodule